// File: doc/BRIEF.md
# Three-Level Line Code Monitor

This block observes a three-level line code stream produced by a zero-substituting bipolar encoder. The stream arrives as three one-hot symbol lines: minus, zero and plus. The block also sees the binary input bit that fed the encoder and the bit recovered by the matching decoder.

On every accepted beat it runs three checks:

- The symbol is exactly one-hot.
- The line has not carried four zero symbols in a row.
- After a warm-up period, the recovered bit equals the input bit from six beats earlier.

Each failed check sets a sticky error flag. The flag stays set until software-free control logic pulses `clr`. A one-cycle pulse marks the beat on which a flag first went high.

The monitored stream enters through a valid/ready port. The monitor never applies back-pressure: `s_ready` is high whenever reset is released. A beat is accepted on a rising clock edge with `s_valid` high, and nothing is sampled on cycles with `s_valid` low. Error indices are fixed:

| Bit | Error |
|-----|-------|
| 0 | non-one-hot symbol |
| 1 | zero run |
| 2 | round-trip mismatch |

Top module: `lc_monitor`

## Requirements
- R1: `s_ready` is 1 whenever `rst_n` is high, so every cycle with `s_valid` high is an accepted beat.
- R2: An accepted beat whose symbol lines {minus,zero,plus} do not have exactly one bit set sets `err_sticky[0]` at that clock edge.
- R3: An accepted beat that completes a fourth consecutive accepted zero-only symbol (zero=1, minus=0, plus=0) sets `err_sticky[1]`. Any other accepted symbol, including an illegal one, restarts the run. The run count saturates at four.
- R4: During the first six accepted beats after reset, `bit_out` is not compared and cannot set `err_sticky[2]`.
- R5: From the seventh accepted beat on, an accepted beat whose `bit_out` differs from the `bit_in` of the sixth-previous accepted beat sets `err_sticky[2]`.
- R6: A set sticky bit stays set until a cycle with `clr` high clears it. A detection on the same edge as `clr` leaves that bit set.
- R7: `err_pulse[i]` is high for exactly the cycle after the edge at which bit i was detected while `err_sticky[i]` was 0. Otherwise it is low.
- R8: Cycles with `s_valid` low neither advance the zero run, the warm-up count or the bit history, nor raise any error.
- R9: Reset (`rst_n` low, asynchronous) clears all flags, pulses, the zero-run count, the warm-up count and the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Beat present on the symbol/bit lines |
| s_ready | output | 1 | Monitor accepts the beat (never stalls) |
| sym_minus | input | 1 | Negative-level symbol line |
| sym_zero | input | 1 | Zero-level symbol line |
| sym_plus | input | 1 | Positive-level symbol line |
| bit_in | input | 1 | Binary bit entering the encoder |
| bit_out | input | 1 | Binary bit leaving the decoder |
| clr | input | 1 | Clears all sticky flags |
| err_sticky | output | 3 | Sticky flags: [0] non-one-hot, [1] zero run, [2] mismatch |
| err_pulse | output | 3 | One-cycle first-detection pulses, same indexing |

## Verification
The assertions assume that `s_valid`, the symbol lines and `clr` are driven to known values in every cycle after reset. They also assume the history is only meaningful once six beats have been accepted.

The stimulus changes inputs only on the falling edge, so every line is stable around the sampling edge. It deliberately presents illegal symbols, long zero runs, idle gaps carrying zero levels, and corrupted decoder bits. A reference model in the bench decides which of these must raise a flag.

// File: rtl/lc_mon_pkg.sv
package lc_mon_pkg;
  localparam int unsigned ERR_N    = 3;
  localparam int unsigned ERR_EXCL = 0;
  localparam int unsigned ERR_RUN  = 1;
  localparam int unsigned ERR_MIS  = 2;

  typedef struct packed {
    logic minus;
    logic zero;
    logic plus;
  } sym_t;

  function automatic logic sym_onehot(sym_t s);
    return (s.minus ^ s.zero ^ s.plus) && !(s.minus && s.zero && s.plus);
  endfunction
endpackage

// File: rtl/lc_sym_check.sv
module lc_sym_check
  import lc_mon_pkg::*;
(
  input  logic valid,
  input  sym_t sym,
  output logic det_excl,
  output logic is_zero
);
  always_comb begin
    det_excl = valid && !sym_onehot(sym);
    is_zero  = sym.zero && !sym.minus && !sym.plus;
  end
endmodule

// File: rtl/lc_zero_run.sv
module lc_zero_run #(
  parameter int unsigned RUN_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic is_zero,
  output logic det_run
);
  localparam int unsigned CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    if (!is_zero)         run_d = '0;
    else if (run_q < LIM) run_d = run_q + 1'b1;
    else                  run_d = run_q;
    det_run = valid && is_zero && (run_d == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (valid) run_q <= run_d;
  end

  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) run_q <= LIM);
  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !valid |=> $stable(run_q));
endmodule

// File: rtl/lc_roundtrip.sv
module lc_roundtrip #(
  parameter int unsigned DELAY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic bit_in,
  input  logic bit_out,
  output logic det_mis
);
  localparam int unsigned WW = $clog2(DELAY + 1);
  localparam logic [WW-1:0] FULL = WW'(DELAY);

  logic [DELAY-1:0] hist_q;
  logic [WW-1:0]    warm_q;
  logic             filled;

  assign filled  = (warm_q == FULL);
  assign det_mis = valid && filled && (bit_out != hist_q[DELAY-1]);

  generate
    if (DELAY > 1) begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hist_q <= '0;
        else if (valid) hist_q <= {hist_q[DELAY-2:0], bit_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hist_q <= '0;
        else if (valid) hist_q <= bit_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 warm_q <= '0;
    else if (valid && !filled)  warm_q <= warm_q + 1'b1;
  end

  // R4
  warm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) warm_q <= FULL);
  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !valid |=> $stable(hist_q) && $stable(warm_q));
endmodule

// File: rtl/lc_err_latch.sv
module lc_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic clr,
  output logic sticky,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      sticky <= (sticky && !clr) || det;
      pulse  <= det && !sticky;
    end
  end

  // R7
  pulse_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) pulse |-> sticky);
  // R6
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n) sticky && !clr |=> sticky);
  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) pulse && !clr |=> !pulse);
endmodule

// File: rtl/lc_monitor.sv
module lc_monitor
  import lc_mon_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 4,
  parameter int unsigned DELAY     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             sym_minus,
  input  logic             sym_zero,
  input  logic             sym_plus,
  input  logic             bit_in,
  input  logic             bit_out,
  input  logic             clr,
  output logic [ERR_N-1:0] err_sticky,
  output logic [ERR_N-1:0] err_pulse
);
  sym_t             sym;
  logic             is_zero;
  logic [ERR_N-1:0] det;
  logic             beat;

  assign s_ready = rst_n;
  assign beat    = s_valid && s_ready;
  assign sym     = '{minus: sym_minus, zero: sym_zero, plus: sym_plus};

  lc_sym_check u_sym (
    .valid    (beat),
    .sym      (sym),
    .det_excl (det[ERR_EXCL]),
    .is_zero  (is_zero)
  );

  lc_zero_run #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (beat),
    .is_zero (is_zero),
    .det_run (det[ERR_RUN])
  );

  lc_roundtrip #(.DELAY(DELAY)) u_rt (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (beat),
    .bit_in  (bit_in),
    .bit_out (bit_out),
    .det_mis (det[ERR_MIS])
  );

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    lc_err_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .det    (det[i]),
      .clr    (clr),
      .sticky (err_sticky[i]),
      .pulse  (err_pulse[i])
    );
  end

  // R8
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !s_valid |=> err_pulse == '0);
  // R2
  excl_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !$onehot({sym_minus, sym_zero, sym_plus}) |=> err_sticky[ERR_EXCL]);
  // R1
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n) s_ready);
endmodule

// File: tb/tb_lc_monitor.sv
module tb_lc_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic sym_minus = 1'b0, sym_zero = 1'b0, sym_plus = 1'b0;
  logic bit_in = 1'b0, bit_out = 1'b0, clr = 1'b0;
  logic [2:0] err_sticky, err_pulse;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  lc_monitor dut (.*);

  // reference model state
  bit    m_hist[$];
  int    m_run = 0, m_warm = 0;
  bit [2:0] m_sticky = 0;
  logic [5:0] expq[$];
  bit    prev = 0;

  function automatic string tag(int i, bit is_pulse);
    if (is_pulse) return "R7";
    case (i) 0: return "R2"; 1: return "R3"; default: return "R5"; endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hist.delete(); m_run = 0; m_warm = 0; m_sticky = 0; expq.delete();
  endtask

  // driver: one cycle of stimulus, pushes expected outputs
  task automatic step(bit v, bit n, bit z, bit p, bit bi, bit corrupt, bit c);
    bit [2:0] det = 0, pulse;
    bit bo;
    @(negedge clk);
    bo = (m_hist.size() == 6) ? m_hist[0] : ~bi;  // during warm-up, garbage (R4)
    bo ^= corrupt;
    s_valid = v; sym_minus = n; sym_zero = z; sym_plus = p;
    bit_in = bi; bit_out = bo; clr = c;
    if (v) begin
      det[0] = (int'(n) + int'(z) + int'(p)) != 1;
      if (z && !n && !p) m_run = (m_run < 4) ? m_run + 1 : 4; else m_run = 0;
      det[1] = z && !n && !p && m_run == 4;
      if (m_warm == 6) begin
        det[2] = bo != m_hist[0];
        void'(m_hist.pop_front());
      end else m_warm++;
      m_hist.push_back(bi);
    end
    pulse = det & ~m_sticky;
    m_sticky = (c ? 3'b0 : m_sticky) | det;
    expq.push_back({m_sticky, pulse});
  endtask

  task automatic sym_beat(int s, bit corrupt = 0);
    prev = ~prev;
    case (s)
      0: step(1, 0, 1, 0, prev, corrupt, 0);
      1: step(1, 0, 0, 1, prev, corrupt, 0);
      default: step(1, 1, 0, 0, prev, corrupt, 0);
    endcase
  endtask

  // monitor: compares after each active edge
  initial forever begin
    @(posedge clk); #1;
    if (rst_n && expq.size() > 0) begin
      logic [5:0] e;
      e = expq.pop_front();
      check(s_ready === 1'b1, "R1", s_ready, 1);
      for (int i = 0; i < 3; i++) begin
        check(err_sticky[i] === e[3+i], tag(i, 0), err_sticky[i], e[3+i]);
        check(err_pulse[i] === e[i], tag(i, 1), err_pulse[i], e[i]);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; s_valid = 0; clr = 0;
    model_reset();
    repeat (2) @(negedge clk);
    // R9: all outputs cleared while in reset
    check(err_sticky === 3'b0, "R9", err_sticky, 0);
    check(err_pulse === 3'b0, "R9", err_pulse, 0);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R4: warm-up beats with garbage decoded bits, R2/R3 clean
    for (int i = 0; i < 6; i++) sym_beat(1 + (i % 2));
    // clean stream with correct decode (R5 no flag)
    for (int i = 0; i < 20; i++) sym_beat(i % 3);
    // R3: three zeros then a nonzero, repeated: no flag
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 3; i++) sym_beat(0);
      sym_beat(1);
    end
    // R8: idle cycles showing zero level do not extend run
    sym_beat(0); sym_beat(0);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 1, 0);
    sym_beat(1);
    // R3: illegal symbol with zero line set restarts the run (also R2)
    sym_beat(0); sym_beat(0); sym_beat(0);
    step(1, 0, 1, 1, 0, 0, 0); prev = 0;
    sym_beat(0);
    // R6: clear, then four zeros in a row
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) sym_beat(0);  // R3 saturate, R7 single pulse
    sym_beat(2);
    // R2: all-zero and all-one symbols
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 1, 1, 0, 0);
    // R5: corrupted decoded bit after warm-up
    sym_beat(1); sym_beat(2, 1); sym_beat(1); sym_beat(2, 1);
    // R6: clear on same edge as a new detection keeps it set
    step(1, 1, 0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0);  // R6 stays clear
    // R9: reset mid-stream, then warm-up again (R4)
    do_reset();
    for (int i = 0; i < 6; i++) sym_beat(1 + (i % 2), 1);
    sym_beat(1); sym_beat(2, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule